// File: doc/BRIEF.md
# Masked Vector Merge Datapath

This block is the register side of a vector unit that runs if/else code without branches. It holds one vector register and a small bank of one-bit-per-element mask registers. A single opcode, strobed by a valid bit, chooses one of five operations:

- load a whole vector;
- compare every element of the register against zero into a mask;
- write the complement of one mask into another;
- load a vector only into the element slots that a mask enables;
- read the whole register out.

Element data for each operation arrives as one flat parallel word. A typical sequence first loads the condition vector and compares it into mask 0. It then loads the "then" data under mask 0. Next it inverts mask 0 into mask 1 and loads the "else" data under mask 1. Finally it reads the merged result. Each operation takes effect at the clock edge that accepts it. A read returns its data on the cycle after.

Top module: `vmask_merge_core`

## Requirements
- R1: While reset is asserted, `op_ready` and `rd_valid` are 0. After reset releases, every element of the vector register and every mask bit is 0, and `op_ready` rises on the first clock edge after release.
- R2: Opcode 0 (load) with `op_valid` high writes all elements of `data_in` into the vector register at that edge.
- R3: Opcode 1 (compare) sets bit i of mask `mask_dst` to 1 exactly when element i of the vector register, read as signed two's complement, is greater than zero. Zero and negative elements give 0. Other masks are unchanged.
- R4: Opcode 2 (mask invert) writes the bitwise complement of mask `mask_src` into mask `mask_dst`.
- R5: Opcode 3 (masked load) writes element i of `data_in` only where bit i of mask `mask_src` is 1. All other elements keep their old value.
- R6: Opcode 4 (read) makes `rd_valid` high for exactly the next cycle, with `rd_data` equal to the whole register as it was at the accepting edge, regardless of any mask. `rd_valid` is 0 in every cycle that does not follow an accepted read.
- R7: With `op_valid` low, or with a reserved opcode 5, 6 or 7, neither the register nor any mask changes.
- R8: Loading 5,0,1,0,0,2,3,4, comparing into mask 0, loading B under mask 0, inverting mask 0 into mask 1, and loading C under mask 1 leaves B1,C2,B3,C4,C5,B6,B7,B8 in the register.
- R9: Element i occupies bits [i*EW +: EW] of both `data_in` and `rd_data`. Element 0 is in the least significant position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (0 load, 1 compare, 2 invert, 3 masked load, 4 read) |
| mask_dst | input | SELW | Mask written by compare and invert |
| mask_src | input | SELW | Mask read by invert and masked load |
| data_in | input | ELEMS*EW | Parallel element data |
| op_ready | output | 1 | High once the datapath accepts operations |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | ELEMS*EW | Full register contents from the last read |

## Verification
A wrong element or mask bit stays hidden until a read. Each test therefore ends in a read, and the bench queues the value it expects one cycle after that read. A corrupted mask shows up as a wrong element after the next masked load and read. This takes three cycles at least. It shows only in the element positions where the bad bit gates a write. For this reason the compare tests mix positive, zero, negative and extreme values across all element positions. Any extra or missing `rd_valid` pulse is flagged in the cycle where it occurs.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_CMPGT = 3'd1,
    OP_MNOT  = 3'd2,
    OP_LOADM = 3'd3,
    OP_READ  = 3'd4
  } vmm_op_e;

  typedef struct packed {
    logic load;
    logic cmp;
    logic mnot;
    logic loadm;
    logic read;
  } vmm_strobe_t;

endpackage

// File: rtl/vmm_decode.sv
module vmm_decode
  import vmm_pkg::*;
(
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  output vmm_strobe_t strb
);
  always_comb begin
    strb = '0;
    if (op_valid) begin
      unique case (op_code)
        OP_LOAD:  strb.load  = 1'b1;
        OP_CMPGT: strb.cmp   = 1'b1;
        OP_MNOT:  strb.mnot  = 1'b1;
        OP_LOADM: strb.loadm = 1'b1;
        OP_READ:  strb.read  = 1'b1;
        default:  strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/vmm_mask_bank.sv
module vmm_mask_bank #(
  parameter int ELEMS = 8,
  parameter int NMASK = 2,
  parameter int SELW  = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmp_wr,
  input  logic                        inv_wr,
  input  logic [SELW-1:0]             dst_sel,
  input  logic [SELW-1:0]             src_sel,
  input  logic [ELEMS-1:0]            cmp_bits,
  output logic [NMASK-1:0][ELEMS-1:0] masks_q,
  output logic [ELEMS-1:0]            sel_mask
);
  logic [ELEMS-1:0] inv_bits;

  always_comb begin
    sel_mask = '0;
    for (int k = 0; k < NMASK; k++) begin
      if (src_sel == SELW'(k)) sel_mask = masks_q[k];
    end
  end

  assign inv_bits = ~sel_mask;

  for (genvar m = 0; m < NMASK; m++) begin : g_mask
    logic hit;
    assign hit = (dst_sel == SELW'(m));
    always_ff @(posedge clk) begin
      if (!rst_n)               masks_q[m] <= '0;
      else if (cmp_wr && hit)   masks_q[m] <= cmp_bits;
      else if (inv_wr && hit)   masks_q[m] <= inv_bits;
    end
  end
endmodule

// File: rtl/vmm_vreg.sv
module vmm_vreg #(
  parameter int ELEMS = 8,
  parameter int EW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ELEMS-1:0]      wr_en,
  input  logic [ELEMS*EW-1:0]   wdata,
  output logic [ELEMS*EW-1:0]   q
);
  for (genvar i = 0; i < ELEMS; i++) begin : g_elem
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i*EW +: EW] <= '0;
      else if (wr_en[i]) q[i*EW +: EW] <= wdata[i*EW +: EW];
    end
  end
endmodule

// File: rtl/vmm_readout.sv
module vmm_readout #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic [DW-1:0] vin,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= vin;
    end
  end
endmodule

// File: rtl/vmask_merge_core.sv
module vmask_merge_core
  import vmm_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int EW    = 16,
  parameter int NMASK = 2,
  parameter int SELW  = (NMASK > 1) ? $clog2(NMASK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [2:0]            op_code,
  input  logic [SELW-1:0]       mask_dst,
  input  logic [SELW-1:0]       mask_src,
  input  logic [ELEMS*EW-1:0]   data_in,
  output logic                  op_ready,
  output logic                  rd_valid,
  output logic [ELEMS*EW-1:0]   rd_data
);
  localparam int DW = ELEMS * EW;

  function automatic logic [ELEMS-1:0] positive_bits(input logic [DW-1:0] v);
    logic [ELEMS-1:0] r;
    for (int i = 0; i < ELEMS; i++) begin
      r[i] = ($signed(v[i*EW +: EW]) > 0);
    end
    return r;
  endfunction

  vmm_strobe_t                 strb;
  logic [DW-1:0]               vreg_q;
  logic [NMASK-1:0][ELEMS-1:0] masks_q;
  logic [ELEMS-1:0]            sel_mask;
  logic [ELEMS-1:0]            cmp_bits;
  logic [ELEMS-1:0]            wr_en;
  logic                        ready_q;

  vmm_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .strb     (strb)
  );

  assign cmp_bits = positive_bits(vreg_q);

  vmm_mask_bank #(.ELEMS(ELEMS), .NMASK(NMASK), .SELW(SELW)) u_masks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_wr   (strb.cmp),
    .inv_wr   (strb.mnot),
    .dst_sel  (mask_dst),
    .src_sel  (mask_src),
    .cmp_bits (cmp_bits),
    .masks_q  (masks_q),
    .sel_mask (sel_mask)
  );

  always_comb begin
    if (strb.load)       wr_en = '1;
    else if (strb.loadm) wr_en = sel_mask;
    else                 wr_en = '0;
  end

  vmm_vreg #(.ELEMS(ELEMS), .EW(EW)) u_vreg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (data_in),
    .q     (vreg_q)
  );

  vmm_readout #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (strb.read),
    .vin       (vreg_q),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign op_ready = ready_q;

endmodule

// File: rtl/vmm_checker.sv
module vmm_checker
  import vmm_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int EW    = 16,
  parameter int NMASK = 2,
  parameter int SELW  = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        op_valid,
  input logic [2:0]                  op_code,
  input logic [SELW-1:0]             mask_dst,
  input logic [SELW-1:0]             mask_src,
  input logic [ELEMS*EW-1:0]         data_in,
  input logic                        op_ready,
  input logic                        rd_valid,
  input logic [ELEMS*EW-1:0]         rd_data,
  input logic [ELEMS*EW-1:0]         vreg_q,
  input logic [NMASK-1:0][ELEMS-1:0] masks_q
);
  localparam int DW = ELEMS * EW;

  function automatic logic [DW-1:0] widen(input logic [ELEMS-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < ELEMS; i++) r[i*EW +: EW] = {EW{m[i]}};
    return r;
  endfunction

  function automatic logic [ELEMS-1:0] sign_ok(input logic [DW-1:0] v);
    logic [ELEMS-1:0] r;
    for (int i = 0; i < ELEMS; i++)
      r[i] = !v[i*EW + EW - 1] && (v[i*EW +: EW] != '0);
    return r;
  endfunction

  logic fire;
  assign fire = op_valid && op_ready;

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> op_ready);

  a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOAD) |=> vreg_q == $past(data_in));

  a_r3_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMPGT) |=> masks_q[$past(mask_dst)] == $past(sign_ok(vreg_q)));

  a_r4_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MNOT) |=> masks_q[$past(mask_dst)] == ~$past(masks_q[mask_src]));

  a_r5_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOADM) |=>
      ((vreg_q ^ $past(vreg_q)) & ~$past(widen(masks_q[mask_src]))) == '0);

  a_r5_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOADM) |=>
      ((vreg_q ^ $past(data_in)) & $past(widen(masks_q[mask_src]))) == '0);

  a_r6_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_READ) |=> rd_valid && rd_data == $past(vreg_q));

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && op_code == OP_READ) |=> !rd_valid);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > OP_READ) |=> $stable(vreg_q) && $stable(masks_q));

endmodule

bind vmask_merge_core vmm_checker #(
  .ELEMS(ELEMS), .EW(EW), .NMASK(NMASK), .SELW(SELW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .mask_dst (mask_dst),
  .mask_src (mask_src),
  .data_in  (data_in),
  .op_ready (op_ready),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .vreg_q   (vreg_q),
  .masks_q  (masks_q)
);

// File: tb/sim_vmask_merge_core.sv
`timescale 1ns/1ps
module sim_vmask_merge_core;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int DW = N * W;

  typedef struct {
    logic [DW-1:0] data;
    int            due;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic [0:0]    mask_dst = 1'b0;
  logic [0:0]    mask_src = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          op_ready;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  exp_t q[$];

  logic [DW-1:0] mv;
  logic [N-1:0]  mm [2];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vmask_merge_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .mask_dst(mask_dst), .mask_src(mask_src), .data_in(data_in),
    .op_ready(op_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of the requirements: the compare works on element sign and value
  task automatic model(input logic [2:0] op, input int d, input int s, input logic [DW-1:0] dat);
    case (op)
      3'd0: mv = dat;
      3'd1: for (int i = 0; i < N; i++) begin
              logic signed [W-1:0] e;
              e = mv[i*W +: W];
              mm[d][i] = (e >= 1);
            end
      3'd2: mm[d] = ~mm[s];
      3'd3: for (int i = 0; i < N; i++) if (mm[s][i]) mv[i*W +: W] = dat[i*W +: W];
      default: ;
    endcase
  endtask

  task automatic op(input logic [2:0] c, input int d, input int s, input logic [DW-1:0] dat, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; mask_dst = d[0]; mask_src = s[0]; data_in = dat;
    if (c == 3'd4) begin
      exp_t e;
      e.data = mv; e.due = cyc + 1; e.req = req;
      q.push_back(e);
    end
    model(c, d, s, dat);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
      data_in = {DW{1'b1}};
    end
  endtask

  // Monitor: pops expected read results in the cycle they are due
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(rd_valid === 1'b1 && rd_data === e.data, e.req, rd_data, e.data);
      end else if (rd_valid !== 1'b0) begin
        check(1'b0, "R6 spurious rd_valid", {{(DW-1){1'b0}}, rd_valid}, '0);
      end
    end
  end

  function automatic logic [DW-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [DW-1:0] r;
    int t [8];
    t = '{a0, a1, a2, a3, a4, a5, a6, a7};
    for (int i = 0; i < 8; i++) r[i*W +: W] = t[i][W-1:0];
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] bvec, cvec, expv;
    mv = '0; mm[0] = '0; mm[1] = '0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check(op_ready === 1'b0 && rd_valid === 1'b0, "R1 outputs low in reset",
          {op_ready, rd_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_ready === 1'b1, "R1 ready after release", op_ready, 1);
    op(3'd4, 0, 0, '0, "R1 register cleared");
    // R1: masks cleared, so a masked load under either mask changes nothing
    op(3'd3, 0, 0, '1, "R1");
    op(3'd3, 0, 1, '1, "R1");
    op(3'd4, 0, 0, '0, "R1 masks cleared");

    // R2 and R9: element ordering
    op(3'd0, 0, 0, pack8(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888), "R2");
    op(3'd4, 0, 0, '0, "R2 R9 full load");
    idle(1);
    check(rd_data[W-1:0] === 16'h1111 && rd_data[7*W +: W] === 16'h8888, "R9 element position",
          rd_data, pack8(16'h1111, 0, 0, 0, 0, 0, 0, 16'h8888));

    // R8: the if/else merge example
    bvec = pack8(16'hB001, 16'hB002, 16'hB003, 16'hB004, 16'hB005, 16'hB006, 16'hB007, 16'hB008);
    cvec = pack8(16'hC001, 16'hC002, 16'hC003, 16'hC004, 16'hC005, 16'hC006, 16'hC007, 16'hC008);
    op(3'd0, 0, 0, pack8(5, 0, 1, 0, 0, 2, 3, 4), "R8");
    op(3'd1, 0, 0, '0, "R3");
    op(3'd3, 0, 0, bvec, "R5");
    op(3'd2, 1, 0, '0, "R4");
    op(3'd3, 0, 1, cvec, "R5");
    expv = pack8(16'hB001, 16'hC002, 16'hB003, 16'hC004, 16'hC005, 16'hB006, 16'hB007, 16'hB008);
    check(mv === expv, "R8 bench model", mv, expv);
    op(3'd4, 0, 0, '0, "R8 merged if/else");

    // R3: signed compare with negatives, zero and extremes into mask 1
    op(3'd0, 0, 0, pack8(16'hFFFF, 16'h8000, 0, 1, 16'h7FFF, 16'hFF00, 16'h0100, 16'h8001), "R3");
    op(3'd1, 1, 0, '0, "R3");
    op(3'd0, 0, 0, '0, "R3");
    op(3'd3, 0, 1, '1, "R3");
    op(3'd4, 0, 0, '0, "R3 signed compare");
    // R3: mask 0 unchanged by compare into mask 1
    op(3'd0, 0, 0, '0, "R3");
    op(3'd3, 0, 0, '1, "R3");
    op(3'd4, 0, 0, '0, "R3 other mask kept");

    // R4: invert mask 1 into mask 0, then use it
    op(3'd2, 0, 1, '0, "R4");
    op(3'd3, 0, 0, pack8(9, 9, 9, 9, 9, 9, 9, 9), "R4");
    op(3'd4, 0, 0, '0, "R4 invert");

    // R7: idle with junk data, and reserved opcodes
    idle(3);
    op(3'd4, 0, 0, '0, "R7 idle no change");
    op(3'd5, 0, 0, '0, "R7");
    op(3'd6, 1, 1, '1, "R7");
    op(3'd7, 0, 1, '1, "R7");
    op(3'd4, 0, 0, '0, "R7 reserved no change");

    // R6: back-to-back reads, read ignores masks
    op(3'd4, 0, 0, '0, "R6 read one");
    op(3'd4, 0, 0, '0, "R6 read two");
    idle(2);

    // Mixed random sequence against the model
    for (int k = 0; k < 400; k++) begin
      logic [DW-1:0] rv;
      for (int i = 0; i < N; i++) rv[i*W +: W] = W'($urandom_range(0, 65535));
      if ($urandom_range(0, 5) == 0) begin
        idle(1);
      end else begin
        logic [2:0] c;
        c = 3'($urandom_range(0, 7));
        op(c, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), rv, "R2 R3 R4 R5 R6 R7 random");
      end
    end
    op(3'd4, 0, 0, '0, "R5 final state");
    idle(4);
    check(q.size() == 0, "R6 all reads returned", DW'(q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule